// File: doc/BRIEF.md
# I/O Register Access and Single-Bit Operation Unit

This block sits between an instruction pipeline and a generic peripheral register bus. It accepts register accesses from two address paths and turns them into bus reads and writes. The port path carries a 6-bit I/O number, 0x00 to 0x3F, and adds an offset of 0x20 to reach the data-space address. The memory path carries a 9-bit data address and uses it unchanged, so it can also reach the extended region 0x60 to 0x1FF, which the port path cannot reach.

On the lower 32 I/O registers the block also sets or clears a single bit and tests a single bit so that the pipeline can skip an instruction. A bit set or clear is a two-cycle read-modify-write of the whole register. Any write-one-to-clear flag that reads as 1 is written back as 1, so it is cleared as a side effect. The block holds one sample status register of that kind. It also holds one reserved address, which ignores writes and reads as zero. Out-of-window bit operations and out-of-range port accesses return an error response and cause no bus activity.

Top module: `io_bitop_unit`

## Requirements
- R1: Operation code 0 is a port-path read and code 1 is a port-path write. I/O number N (0x00 to 0x3F) appears on the bus as data address N + 0x20, and the read data comes back in the response.
- R2: Operation code 2 is a memory-path read and code 3 is a memory-path write. They use the data address unchanged, from 0x20 up to 0x1FF, including the extended region 0x60 to 0x1FF. A memory-path address below 0x20 gives an error response.
- R3: A port-path access whose I/O number is above 0x3F gives an error response. It causes no bus read and no bus write.
- R4: A bit operation (codes 4 to 7) on an I/O number of 0x20 or above gives an error response, with skip 0 and no bus access.
- R5: Code 4 sets and code 5 clears bit `req_bit` of the register. The full register is read in the accept cycle and registered. The modified value is written in the next cycle while `busy` is 1, and the response arrives two clock edges after acceptance.
- R6: The status register sits at I/O number 0x0E (data address 0x2E). A 1 on a bit of `flag_set` sets that flag. A write clears every flag where the written data has a 1. When a set and a clear hit the same flag in the same cycle, the set wins.
- R7: A bit set or clear on the status register writes back the whole modified value. Every flag read as 1 is therefore cleared, except a flag that the operation itself writes as 0. Clearing a set flag leaves that flag set.
- R8: Code 6 reports skip = 1 when the selected bit is 1. Code 7 reports skip = 1 when the selected bit is 0. Both return the register value as read data.
- R9: The reserved register at I/O number 0x1D (data address 0x3D) reads as 0. Plain writes and bit operations on it cause no bus write and no error.
- R10: Reads, writes, tests and error responses arrive one clock edge after acceptance. A request presented while `busy` is 1 is ignored.
- R11: After reset, `rsp_valid` and `busy` are 0 and all status flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 3 | Operation code (0 to 7) |
| req_addr | input | 9 | I/O number (port path, bit ops) or data address (memory path) |
| req_bit | input | 3 | Bit index for bit operations |
| req_wdata | input | 8 | Write data for plain writes |
| busy | output | 1 | Read-modify-write in its write cycle; requests ignored |
| rsp_valid | output | 1 | Response valid pulse |
| rsp_err | output | 1 | Illegal access flagged |
| rsp_skip | output | 1 | Bit test matched requested polarity |
| rsp_rdata | output | 8 | Read data (0 for writes, bit set/clear and errors) |
| bus_addr | output | 9 | Data-space address on the register bus |
| bus_rd | output | 1 | Register bus read strobe |
| bus_wr | output | 1 | Register bus write strobe |
| bus_wdata | output | 8 | Register bus write data |
| bus_rdata | input | 8 | Register bus read data (same cycle) |
| flag_set | input | 8 | Event inputs setting status flags |

## Verification
Plain accesses are tried on both paths against the same register. This shows that the port path applies the 0x20 offset and the memory path does not, and the boundary numbers 0x3F and 0x40 separate a legal port access from an illegal one. Bit set and clear are tried on an ordinary register, where only the chosen bit may change. They are also tried on the status register with several flags set, where the clearing side effect must appear and a cleared-by-operation flag must survive. Bit tests are run with both polarities against a 1 bit and a 0 bit, and against an out-of-window number. Writes and bit operations on the reserved number, and a request presented during the write cycle, must leave the bus write count and the register contents unchanged.

// File: rtl/io_bitop_pkg.sv
package io_bitop_pkg;

    localparam int DATA_W       = 8;
    localparam int DATA_AW      = 9;
    localparam int IO_AW        = 6;
    localparam int IO_DM_OFFSET = 32;
    localparam int BIT_WINDOW   = 32;

    typedef enum logic [2:0] {
        OP_IO_RD    = 3'd0,
        OP_IO_WR    = 3'd1,
        OP_DM_RD    = 3'd2,
        OP_DM_WR    = 3'd3,
        OP_BSET     = 3'd4,
        OP_BCLR     = 3'd5,
        OP_SKIP_SET = 3'd6,
        OP_SKIP_CLR = 3'd7
    } op_e;

    typedef enum logic {ST_IDLE, ST_WRITE} state_e;

    typedef struct packed {
        logic err;
        logic is_rd;
        logic is_wr;
        logic rmw;
        logic test;
        logic hit_status;
        logic hit_rsvd;
    } dec_t;

    function automatic logic op_is_bit(op_e op);
        return op inside {OP_BSET, OP_BCLR, OP_SKIP_SET, OP_SKIP_CLR};
    endfunction

    function automatic logic op_is_port(op_e op);
        return !(op inside {OP_DM_RD, OP_DM_WR});
    endfunction

endpackage

// File: rtl/io_addr_decode.sv
module io_addr_decode
    import io_bitop_pkg::*;
#(
    parameter int AW        = DATA_AW,
    parameter int STATUS_IO = 14,
    parameter int RSVD_IO   = 29
) (
    input  op_e           op,
    input  logic [AW-1:0] addr,
    output dec_t          dec,
    output logic [AW-1:0] daddr
);
    localparam logic [AW-1:0] OFFSET     = AW'(IO_DM_OFFSET);
    localparam logic [AW-1:0] STATUS_DA  = AW'(STATUS_IO + IO_DM_OFFSET);
    localparam logic [AW-1:0] RSVD_DA    = AW'(RSVD_IO + IO_DM_OFFSET);
    localparam logic [AW-1:0] BIT_LIMIT  = AW'(BIT_WINDOW);

    logic port_path;
    logic port_in_range;

    always_comb begin
        port_path     = op_is_port(op);
        port_in_range = (addr[AW-1:IO_AW] == '0);
        daddr         = port_path ? (addr + OFFSET) : addr;

        if (port_path)
            dec.err = !port_in_range || (op_is_bit(op) && (addr >= BIT_LIMIT));
        else
            dec.err = (addr < OFFSET);

        dec.is_rd      = op inside {OP_IO_RD, OP_DM_RD, OP_SKIP_SET, OP_SKIP_CLR};
        dec.is_wr      = op inside {OP_IO_WR, OP_DM_WR};
        dec.rmw        = op inside {OP_BSET, OP_BCLR};
        dec.test       = op inside {OP_SKIP_SET, OP_SKIP_CLR};
        dec.hit_status = (daddr == STATUS_DA);
        dec.hit_rsvd   = (daddr == RSVD_DA);
    end

endmodule

// File: rtl/io_bit_alu.sv
module io_bit_alu
    import io_bitop_pkg::*;
#(
    parameter int DW = DATA_W,
    localparam int BW = $clog2(DW)
) (
    input  logic [DW-1:0] value,
    input  op_e           op,
    input  logic [BW-1:0] idx,
    output logic [DW-1:0] new_val,
    output logic          match
);
    logic [DW-1:0] mask;

    always_comb begin
        mask    = DW'(1) << idx;
        new_val = (op == OP_BSET) ? (value | mask) : (value & ~mask);
        match   = (value[idx] == (op == OP_SKIP_SET));
    end

endmodule

// File: rtl/io_status_w1c.sv
module io_status_w1c
    import io_bitop_pkg::*;
#(
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [DW-1:0] set_evt,
    input  logic          clr_en,
    input  logic [DW-1:0] clr_mask,
    output logic [DW-1:0] flags
);
    logic [DW-1:0] flags_q;

    always_ff @(posedge clk) begin
        if (rst)
            flags_q <= '0;
        else
            flags_q <= (flags_q & ~(clr_en ? clr_mask : '0)) | set_evt;
    end

    assign flags = flags_q;

    AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (clr_en && (set_evt == '0)) |=> ((flags & $past(clr_mask)) == '0)); // R6

    AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
        (set_evt != '0) |=> ((flags & $past(set_evt)) == $past(set_evt))); // R6

endmodule

// File: rtl/io_bitop_unit.sv
module io_bitop_unit
    import io_bitop_pkg::*;
#(
    parameter int DW        = DATA_W,
    parameter int AW        = DATA_AW,
    parameter int STATUS_IO = 14,
    parameter int RSVD_IO   = 29,
    localparam int BW = $clog2(DW)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_valid,
    input  logic [2:0]    req_op,
    input  logic [AW-1:0] req_addr,
    input  logic [BW-1:0] req_bit,
    input  logic [DW-1:0] req_wdata,
    output logic          busy,
    output logic          rsp_valid,
    output logic          rsp_err,
    output logic          rsp_skip,
    output logic [DW-1:0] rsp_rdata,
    output logic [AW-1:0] bus_addr,
    output logic          bus_rd,
    output logic          bus_wr,
    output logic [DW-1:0] bus_wdata,
    input  logic [DW-1:0] bus_rdata,
    input  logic [DW-1:0] flag_set
);
    localparam logic [AW-1:0] RSVD_DA   = AW'(RSVD_IO + IO_DM_OFFSET);
    localparam logic [AW-1:0] PORT_TOP  = AW'((1 << IO_AW) - 1);
    localparam logic [AW-1:0] BIT_LIMIT = AW'(BIT_WINDOW);

    op_e           op;
    dec_t          dec;
    logic [AW-1:0] daddr;
    state_e        state_q;
    logic          accept;
    logic [DW-1:0] flags;
    logic [DW-1:0] read_val;
    logic          stat_clr;
    logic [DW-1:0] stat_mask;

    op_e           hold_op;
    logic [BW-1:0] hold_bit;
    logic [DW-1:0] hold_rd;
    logic [AW-1:0] hold_addr;
    logic          hold_status;
    logic          hold_rsvd;

    logic [DW-1:0] alu_val;
    op_e           alu_op;
    logic [BW-1:0] alu_bit;
    logic [DW-1:0] alu_new;
    logic          alu_match;

    assign op     = op_e'(req_op);
    assign busy   = (state_q == ST_WRITE);
    assign accept = req_valid && (state_q == ST_IDLE);

    io_addr_decode #(.AW(AW), .STATUS_IO(STATUS_IO), .RSVD_IO(RSVD_IO)) u_dec (
        .op(op), .addr(req_addr), .dec(dec), .daddr(daddr)
    );

    io_status_w1c #(.DW(DW)) u_status (
        .clk(clk), .rst(rst), .set_evt(flag_set),
        .clr_en(stat_clr), .clr_mask(stat_mask), .flags(flags)
    );

    io_bit_alu #(.DW(DW)) u_alu (
        .value(alu_val), .op(alu_op), .idx(alu_bit),
        .new_val(alu_new), .match(alu_match)
    );

    always_comb begin
        if (dec.hit_status)
            read_val = flags;
        else if (dec.hit_rsvd)
            read_val = '0;
        else
            read_val = bus_rdata;

        alu_val = busy ? hold_rd  : read_val;
        alu_op  = busy ? hold_op  : op;
        alu_bit = busy ? hold_bit : req_bit;
    end

    always_comb begin
        bus_rd    = 1'b0;
        bus_wr    = 1'b0;
        bus_addr  = daddr;
        bus_wdata = req_wdata;
        stat_clr  = 1'b0;
        stat_mask = req_wdata;
        if (busy) begin
            bus_addr  = hold_addr;
            bus_wdata = alu_new;
            stat_mask = alu_new;
            if (hold_status)
                stat_clr = 1'b1;
            else if (!hold_rsvd)
                bus_wr = 1'b1;
        end else if (accept && !dec.err) begin
            if ((dec.is_rd || dec.rmw) && !dec.hit_status && !dec.hit_rsvd)
                bus_rd = 1'b1;
            if (dec.is_wr) begin
                if (dec.hit_status)
                    stat_clr = 1'b1;
                else if (!dec.hit_rsvd)
                    bus_wr = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= ST_IDLE;
            rsp_valid   <= 1'b0;
            rsp_err     <= 1'b0;
            rsp_skip    <= 1'b0;
            rsp_rdata   <= '0;
            hold_op     <= OP_IO_RD;
            hold_bit    <= '0;
            hold_rd     <= '0;
            hold_addr   <= '0;
            hold_status <= 1'b0;
            hold_rsvd   <= 1'b0;
        end else begin
            rsp_valid <= 1'b0;
            if (busy) begin
                state_q   <= ST_IDLE;
                rsp_valid <= 1'b1;
                rsp_err   <= 1'b0;
                rsp_skip  <= 1'b0;
                rsp_rdata <= '0;
            end else if (accept) begin
                if (!dec.err && dec.rmw) begin
                    state_q     <= ST_WRITE;
                    hold_op     <= op;
                    hold_bit    <= req_bit;
                    hold_rd     <= read_val;
                    hold_addr   <= daddr;
                    hold_status <= dec.hit_status;
                    hold_rsvd   <= dec.hit_rsvd;
                end else begin
                    rsp_valid <= 1'b1;
                    rsp_err   <= dec.err;
                    rsp_rdata <= (!dec.err && dec.is_rd) ? read_val : '0;
                    rsp_skip  <= !dec.err && dec.test && alu_match;
                end
            end
        end
    end

    AST_PORT_RANGE: assert property (@(posedge clk) disable iff (rst)
        (accept && op_is_port(op) && (req_addr > PORT_TOP)) |=> (rsp_valid && rsp_err)); // R3

    AST_ERR_NO_BUS: assert property (@(posedge clk) disable iff (rst)
        (accept && dec.err) |-> (!bus_rd && !bus_wr)); // R3

    AST_BIT_WINDOW: assert property (@(posedge clk) disable iff (rst)
        (accept && op_is_bit(op) && (req_addr >= BIT_LIMIT)) |=> (rsp_valid && rsp_err && !rsp_skip)); // R4

    AST_RMW_WRITE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        (accept && dec.rmw && !dec.err) |=> (busy && !rsp_valid)); // R5

    AST_RMW_DONE: assert property (@(posedge clk) disable iff (rst)
        busy |=> (rsp_valid && !busy)); // R5

    AST_RSVD_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        bus_wr |-> (bus_addr != RSVD_DA)); // R9

    AST_BUS_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(bus_rd && bus_wr)); // R10

endmodule

// File: tb/io_bitop_unit_test.sv
module io_bitop_unit_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       req_valid = 1'b0;
    logic [2:0] req_op = 3'd0;
    logic [8:0] req_addr = '0;
    logic [2:0] req_bit = '0;
    logic [7:0] req_wdata = '0;
    logic       busy, rsp_valid, rsp_err, rsp_skip;
    logic [7:0] rsp_rdata;
    logic [8:0] bus_addr;
    logic       bus_rd, bus_wr;
    logic [7:0] bus_wdata, bus_rdata;
    logic [7:0] flag_set = '0;

    logic [7:0] mem [0:511];
    int         wr_count;
    int         checks = 0;
    int         errors = 0;
    bit         done = 0;

    always #2.5 clk = ~clk;

    io_bitop_unit uut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
        .req_addr(req_addr), .req_bit(req_bit), .req_wdata(req_wdata),
        .busy(busy), .rsp_valid(rsp_valid), .rsp_err(rsp_err),
        .rsp_skip(rsp_skip), .rsp_rdata(rsp_rdata), .bus_addr(bus_addr),
        .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .flag_set(flag_set)
    );

    assign bus_rdata = mem[bus_addr];

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 512; i++) mem[i] <= 8'h00;
            wr_count <= 0;
        end else if (bus_wr) begin
            mem[bus_addr] <= bus_wdata;
            wr_count      <= wr_count + 1;
        end
    end

    typedef struct packed {
        logic [2:0] op;
        logic [8:0] addr;
        logic [2:0] bidx;
        logic [7:0] wd;
        logic       err;
        logic [7:0] rd;
        logic       skip;
        logic [3:0] tag;
    } vec_t;

    localparam int NV = 22;
    localparam vec_t VECS [0:NV-1] = '{
        '{3'd1, 9'h005, 3'd0, 8'hA5, 1'b0, 8'h00, 1'b0, 4'd1},  // R1 port write
        '{3'd0, 9'h005, 3'd0, 8'h00, 1'b0, 8'hA5, 1'b0, 4'd1},  // R1 port read
        '{3'd2, 9'h025, 3'd0, 8'h00, 1'b0, 8'hA5, 1'b0, 4'd2},  // R2 same reg via memory path
        '{3'd3, 9'h100, 3'd0, 8'h3C, 1'b0, 8'h00, 1'b0, 4'd2},  // R2 extended write
        '{3'd2, 9'h100, 3'd0, 8'h00, 1'b0, 8'h3C, 1'b0, 4'd2},  // R2 extended read
        '{3'd0, 9'h040, 3'd0, 8'h00, 1'b1, 8'h00, 1'b0, 4'd3},  // R3 beyond port range
        '{3'd2, 9'h010, 3'd0, 8'h00, 1'b1, 8'h00, 1'b0, 4'd2},  // R2 below I/O space
        '{3'd4, 9'h005, 3'd1, 8'h00, 1'b0, 8'h00, 1'b0, 4'd5},  // R5 set bit 1
        '{3'd0, 9'h005, 3'd0, 8'h00, 1'b0, 8'hA7, 1'b0, 4'd5},
        '{3'd5, 9'h005, 3'd7, 8'h00, 1'b0, 8'h00, 1'b0, 4'd5},  // R5 clear bit 7
        '{3'd0, 9'h005, 3'd0, 8'h00, 1'b0, 8'h27, 1'b0, 4'd5},
        '{3'd6, 9'h005, 3'd0, 8'h00, 1'b0, 8'h27, 1'b1, 4'd8},  // R8 set bit, skip-if-set
        '{3'd6, 9'h005, 3'd3, 8'h00, 1'b0, 8'h27, 1'b0, 4'd8},  // R8 clear bit, skip-if-set
        '{3'd7, 9'h005, 3'd3, 8'h00, 1'b0, 8'h27, 1'b1, 4'd8},  // R8 clear bit, skip-if-clear
        '{3'd7, 9'h005, 3'd0, 8'h00, 1'b0, 8'h27, 1'b0, 4'd8},  // R8 set bit, skip-if-clear
        '{3'd4, 9'h025, 3'd0, 8'h00, 1'b1, 8'h00, 1'b0, 4'd4},  // R4 set outside window
        '{3'd6, 9'h03F, 3'd2, 8'h00, 1'b1, 8'h00, 1'b0, 4'd4},  // R4 test outside window
        '{3'd1, 9'h01D, 3'd0, 8'hFF, 1'b0, 8'h00, 1'b0, 4'd9},  // R9 reserved write
        '{3'd0, 9'h01D, 3'd0, 8'h00, 1'b0, 8'h00, 1'b0, 4'd9},  // R9 reserved reads 0
        '{3'd2, 9'h03D, 3'd0, 8'h00, 1'b0, 8'h00, 1'b0, 4'd9},  // R9 reserved via memory path
        '{3'd1, 9'h03F, 3'd0, 8'h5A, 1'b0, 8'h00, 1'b0, 4'd1},  // R1 top port number
        '{3'd2, 9'h05F, 3'd0, 8'h00, 1'b0, 8'h5A, 1'b0, 4'd1}   // R1 lands at 0x5F
    };

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic issue(input logic [2:0] op, input logic [8:0] a,
                         input logic [2:0] b, input logic [7:0] wd, output int lat);
        @(negedge clk);
        req_valid = 1'b1; req_op = op; req_addr = a; req_bit = b; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        lat = 1;
        while (!rsp_valid && lat < 8) begin
            @(negedge clk);
            lat++;
        end
    endtask

    task automatic read_io(input logic [8:0] a, input logic [7:0] exp, input string tag);
        int lat;
        issue(3'd0, a, 3'd0, 8'h00, lat);
        check(rsp_valid && !rsp_err && rsp_rdata == exp, tag, rsp_rdata, exp);
    endtask

    task automatic pulse_flags(input logic [7:0] f);
        @(negedge clk);
        flag_set = f;
        @(negedge clk);
        flag_set = 8'h00;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=0x0 expected=0x1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int lat;
        int wc;
        int exp_lat;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(!rsp_valid, "R11 rsp_valid after reset", rsp_valid, 0);
        check(!busy, "R11 busy after reset", busy, 0);
        read_io(9'h00E, 8'h00, "R11 status flags after reset");

        for (int i = 0; i < NV; i++) begin
            issue(VECS[i].op, VECS[i].addr, VECS[i].bidx, VECS[i].wd, lat);
            exp_lat = ((VECS[i].op == 3'd4 || VECS[i].op == 3'd5) && !VECS[i].err) ? 2 : 1;
            check(rsp_valid, $sformatf("R%0d vec %0d valid", VECS[i].tag, i), rsp_valid, 1);
            check(lat == exp_lat, $sformatf("R10 vec %0d latency", i), lat, exp_lat);
            check(rsp_err == VECS[i].err, $sformatf("R%0d vec %0d err", VECS[i].tag, i),
                  rsp_err, VECS[i].err);
            check(rsp_rdata == VECS[i].rd, $sformatf("R%0d vec %0d rdata", VECS[i].tag, i),
                  rsp_rdata, VECS[i].rd);
            check(rsp_skip == VECS[i].skip, $sformatf("R%0d vec %0d skip", VECS[i].tag, i),
                  rsp_skip, VECS[i].skip);
        end

        // R3: illegal port access makes no bus write
        wc = wr_count;
        issue(3'd1, 9'h040, 3'd0, 8'h77, lat);
        check(rsp_err, "R3 err on 0x40 write", rsp_err, 1);
        check(wr_count == wc, "R3 no bus write", wr_count, wc);

        // R9: bit set on reserved register makes no bus write and no error
        wc = wr_count;
        issue(3'd4, 9'h01D, 3'd0, 8'h00, lat);
        check(!rsp_err, "R9 no err on reserved bit op", rsp_err, 0);
        check(wr_count == wc, "R9 no bus write on reserved bit op", wr_count, wc);

        // R5 cycle-by-cycle, R10 request during busy ignored
        @(negedge clk);
        req_valid = 1'b1; req_op = 3'd4; req_addr = 9'h005; req_bit = 3'd4;
        @(negedge clk);
        check(busy, "R5 busy in write cycle", busy, 1);
        check(bus_wr && bus_addr == 9'h025, "R5 write in second cycle", bus_addr, 9'h025);
        check(bus_wdata == 8'h37, "R5 written value", bus_wdata, 8'h37);
        check(!rsp_valid, "R5 no response yet", rsp_valid, 0);
        req_op = 3'd1; req_addr = 9'h006; req_wdata = 8'h99;
        @(negedge clk);
        req_valid = 1'b0;
        check(rsp_valid && !busy, "R5 response after write", rsp_valid, 1);
        read_io(9'h005, 8'h37, "R5 register after set bit 4");
        read_io(9'h006, 8'h00, "R10 request during busy ignored");

        // R6: set events and write-one-to-clear
        pulse_flags(8'h06);
        read_io(9'h00E, 8'h06, "R6 flags set by events");
        issue(3'd1, 9'h00E, 3'd0, 8'h02, lat);
        issue(3'd2, 9'h02E, 3'd0, 8'h00, lat);
        check(rsp_rdata == 8'h04, "R6 write one clears flag", rsp_rdata, 8'h04);
        issue(3'd3, 9'h02E, 3'd0, 8'h04, lat);
        read_io(9'h00E, 8'h00, "R6 all flags cleared");

        // R7: bit set/clear side effects on status register
        pulse_flags(8'h07);
        issue(3'd5, 9'h00E, 3'd2, 8'h00, lat);
        check(lat == 2 && !rsp_err, "R7 clear on status two cycles", lat, 2);
        read_io(9'h00E, 8'h04, "R7 clear bit2 keeps bit2, clears others");
        pulse_flags(8'h01);
        issue(3'd4, 9'h00E, 3'd1, 8'h00, lat);
        read_io(9'h00E, 8'h00, "R7 set bit1 clears every flag");

        // R6: set beats clear in the same cycle
        @(negedge clk);
        flag_set = 8'h01;
        req_valid = 1'b1; req_op = 3'd1; req_addr = 9'h00E; req_wdata = 8'h01;
        @(negedge clk);
        flag_set = 8'h00;
        req_valid = 1'b0;
        read_io(9'h00E, 8'h01, "R6 set wins over clear");

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule